// File: doc/BRIEF.md
# Half-Duplex Collision Jam and Retry Controller

This block takes over the transmit side of a half-duplex link while a frame is being sent and a collision is reported. From the start of each frame it counts bit-time strobes, and it watches a flag that says whether the preamble is still going out. When a collision arrives it drives an all-ones jam pattern onto the transmit data path. If the preamble is still in progress, the jam is held back until the preamble is complete. The jam lasts a fixed number of bit times.

After the jam the block chooses one of three outcomes. A collision that arrived inside the first slot of the frame normally leads to a retry. Before the retry request is raised, the block waits a pseudo-random number of whole slot times. The range of that number doubles with each collision on the same frame, up to a cap. A collision that arrived after the slot window closes the frame with a late-collision flag and no retry. If too many collisions hit one frame, the block gives the frame up and raises a retry-limit flag. The per-frame collision count is cleared when a frame ends normally and when a frame is given up.

Top module: `hdx_coll_ctrl`

## Requirements
- R1: After a collision, `jam_en` is high for exactly JAM_BITS bit-time strobes, with `jam_d` all ones while `jam_en` is high and all zeros otherwise.
- R2: A collision seen while `pre_act` is high keeps `jam_en` low for as long as `pre_act` stays high. The jam begins in the cycle after `pre_act` is sampled low.
- R3: A collision sampled when fewer than SLOT_BITS strobes have passed since `frm_start` (strobes on the collision cycle are not counted) leads to a retry. It raises neither `late_coll` nor `retry_lim`.
- R4: After the n-th collision on a frame that is being retried, `retry_req` pulses for one cycle after k·SLOT_BITS further strobes, where 0 ≤ k ≤ 2^min(n,BACKOFF_CAP) − 1.
- R5: A collision sampled once SLOT_BITS or more strobes have passed since `frm_start` produces a one-cycle `late_coll` pulse and no retry request.
- R6: No outcome is output until the first strobe after the last jam strobe. The outcome pulse appears in the cycle after that strobe is sampled, and at most one of `retry_req`, `late_coll` and `retry_lim` is high in any cycle.
- R7: The MAX_ATTEMPTS-th consecutive collision on one frame produces a one-cycle `retry_lim` pulse instead of a backoff. The collision count is then cleared, so the next collision counts as the first.
- R8: `frm_end` during a frame with no collision ends the frame with no outcome pulse and clears the collision count.
- R9: While `rst_n` is low, every output is low.
- R10: A collision reported outside a frame in progress, whether the block is idle or in backoff, has no effect: no jam and no outcome pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | One-cycle strobe per transmitted bit time |
| coll | input | 1 | Collision reported by the line |
| pre_act | input | 1 | High while the preamble is being sent |
| frm_start | input | 1 | Pulse: a new frame (or retry) starts |
| frm_end | input | 1 | Pulse: frame finished without collision |
| jam_en | output | 1 | Jam pattern owns the transmit data path |
| jam_d | output | DATA_W | Jam data, all ones while jamming |
| retry_req | output | 1 | Pulse: backoff over, retransmit the frame |
| late_coll | output | 1 | Pulse: frame closed with late-collision error |
| retry_lim | output | 1 | Pulse: frame abandoned after too many collisions |

## Verification
The hardest state to reach is the retry-limit exit together with the clearing of the count. It needs MAX_ATTEMPTS collisions in a row on one frame, with a full jam, decision and random backoff between each. The bench first builds up several collisions and then ends a frame cleanly. It then counts exactly fifteen retries before expecting the abandon, so a count that is not cleared shows up as an early abandon. Backoff delays are not predictable from the ports, so each one is checked as a whole multiple of the slot inside the range allowed for that collision number. The bench runs with a shortened slot and a small backoff cap so that these loops stay short.

// File: rtl/hdx_coll_pkg.sv
// Package: shared state type for the half-duplex collision controller.
// Assumes: nothing beyond SystemVerilog enums.
package hdx_coll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for a frame to start
        ST_SEND,      // frame on the wire, counting bit times
        ST_HOLD_PRE,  // collision seen in preamble, jam deferred
        ST_JAM,       // driving the jam pattern
        ST_DECIDE,    // jam done, waiting for next strobe to decide
        ST_BACKOFF    // waiting a random number of slots
    } ctl_state_t;

endpackage

// File: rtl/hdx_bit_window.sv
// Module: counts bit-time strobes since the start of a frame and reports
// whether the collision window (one slot) has been passed.
// Assumes: clear and count_en are never meaningful together; the count
// saturates at SLOT_BITS so it never wraps on long frames.
module hdx_bit_window #(
    parameter int SLOT_BITS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    input  logic bit_stb,
    output logic past_slot
);
    localparam int CW = $clog2(SLOT_BITS + 1);
    localparam logic [CW-1:0] SLOT_V = CW'(SLOT_BITS);

    logic [CW-1:0] cnt;

    // Saturating count of strobes while the frame is being sent.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (count_en && bit_stb && cnt != SLOT_V) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign past_slot = (cnt == SLOT_V);

    // The counter never runs past the window boundary (feeds R5).
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= SLOT_V);

endmodule

// File: rtl/hdx_lfsr.sv
// Module: free-running 16-bit Galois LFSR used as the backoff random source.
// Assumes: OUT_W <= 16; the state is seeded non-zero by reset.
module hdx_lfsr #(
    parameter int OUT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    localparam int LW = 16;
    localparam logic [LW-1:0] TAPS = 16'hB400;
    localparam logic [LW-1:0] SEED = 16'hACE1;

    logic [LW-1:0] state;

    // Advance the sequence every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else begin
            state <= {1'b0, state[LW-1:1]} ^ (state[0] ? TAPS : '0);
        end
    end

    assign rnd = state[OUT_W-1:0];

    // A zero state would lock the generator (feeds R4 spread).
    assert_lfsr_alive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

endmodule

// File: rtl/hdx_backoff_timer.sv
// Module: waits a loaded number of slot times, counted in bit strobes,
// and flags the cycle in which the wait is over.
// Assumes: load is a single-cycle pulse; SLOT_BITS >= 2.
module hdx_backoff_timer #(
    parameter int SLOT_BITS = 512,
    parameter int SLOTS_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SLOTS_W-1:0] slots,
    input  logic               bit_stb,
    output logic               expire
);
    localparam int SC_W = $clog2(SLOT_BITS);
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SLOT_BITS - 1);

    logic               active;
    logic [SLOTS_W-1:0] rem;
    logic [SC_W-1:0]    sc;

    assign expire = active && (rem == '0);

    // Slot countdown: bit strobes fill a slot, each full slot drops rem.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            rem    <= '0;
            sc     <= '0;
        end else if (load) begin
            active <= 1'b1;
            rem    <= slots;
            sc     <= '0;
        end else if (expire) begin
            active <= 1'b0;
        end else if (active && bit_stb) begin
            if (sc == SC_LAST) begin
                sc  <= '0;
                rem <= rem - 1'b1;
            end else begin
                sc <= sc + 1'b1;
            end
        end
    end

    // Remaining slots only ever count down between loads (R4).
    assert_rem_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load) |=> (rem <= $past(rem)));

    // The expiry is a single-cycle event (R4).
    assert_expire_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

endmodule

// File: rtl/hdx_coll_ctrl.sv
// Module: top of the half-duplex collision handler. Sequences jam, the
// retry/late/abandon decision and the backoff before a retry request.
// Assumes: bit_stb is a one-cycle pulse per bit time; frm_start is only
// given when the block is idle; coll and pre_act are synchronous to clk.
module hdx_coll_ctrl #(
    parameter int SLOT_BITS    = 512,
    parameter int JAM_BITS     = 32,
    parameter int MAX_ATTEMPTS = 16,
    parameter int BACKOFF_CAP  = 10,
    parameter int DATA_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              coll,
    input  logic              pre_act,
    input  logic              frm_start,
    input  logic              frm_end,
    output logic              jam_en,
    output logic [DATA_W-1:0] jam_d,
    output logic              retry_req,
    output logic              late_coll,
    output logic              retry_lim
);
    import hdx_coll_pkg::*;

    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam int JAM_W = $clog2(JAM_BITS);
    localparam logic [JAM_W-1:0] JAM_LAST = JAM_W'(JAM_BITS - 1);
    localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(MAX_ATTEMPTS - 1);

    ctl_state_t             state;
    logic [ATT_W-1:0]       attempts;
    logic [ATT_W-1:0]       n_next;
    logic [JAM_W-1:0]       jam_cnt;
    logic                   late_seen;
    logic                   late_q, lim_q, retry_q;
    logic                   past_slot;
    logic                   last_try;
    logic                   tmr_load, tmr_expire;
    logic [BACKOFF_CAP-1:0] rnd, mask;

    assign n_next   = attempts + 1'b1;
    assign last_try = (attempts == ATT_LAST);
    assign tmr_load = (state == ST_DECIDE) && bit_stb && !late_seen && !last_try;

    // Backoff range mask: the low min(n, cap) bits are set.
    for (genvar i = 0; i < BACKOFF_CAP; i++) begin : g_mask
        assign mask[i] = (int'(n_next) > i);
    end

    hdx_bit_window #(.SLOT_BITS(SLOT_BITS)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    ((state == ST_IDLE) && frm_start),
        .count_en (state == ST_SEND),
        .bit_stb  (bit_stb),
        .past_slot(past_slot)
    );

    hdx_lfsr #(.OUT_W(BACKOFF_CAP)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .rnd  (rnd)
    );

    hdx_backoff_timer #(.SLOT_BITS(SLOT_BITS), .SLOTS_W(BACKOFF_CAP)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .slots  (rnd & mask),
        .bit_stb(bit_stb),
        .expire (tmr_expire)
    );

    // Control sequence: send, jam, decide, back off; one-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            attempts  <= '0;
            jam_cnt   <= '0;
            late_seen <= 1'b0;
            late_q    <= 1'b0;
            lim_q     <= 1'b0;
            retry_q   <= 1'b0;
        end else begin
            late_q  <= 1'b0;
            lim_q   <= 1'b0;
            retry_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (frm_start) state <= ST_SEND;
                end
                ST_SEND: begin
                    if (coll) begin
                        late_seen <= past_slot;
                        jam_cnt   <= '0;
                        state     <= pre_act ? ST_HOLD_PRE : ST_JAM;
                    end else if (frm_end) begin
                        attempts <= '0;
                        state    <= ST_IDLE;
                    end
                end
                ST_HOLD_PRE: begin
                    if (!pre_act) state <= ST_JAM;
                end
                ST_JAM: begin
                    if (bit_stb) begin
                        if (jam_cnt == JAM_LAST) state <= ST_DECIDE;
                        else                     jam_cnt <= jam_cnt + 1'b1;
                    end
                end
                ST_DECIDE: begin
                    if (bit_stb) begin
                        if (late_seen) begin
                            late_q   <= 1'b1;
                            attempts <= '0;
                            state    <= ST_IDLE;
                        end else if (last_try) begin
                            lim_q    <= 1'b1;
                            attempts <= '0;
                            state    <= ST_IDLE;
                        end else begin
                            attempts <= n_next;
                            state    <= ST_BACKOFF;
                        end
                    end
                end
                ST_BACKOFF: begin
                    if (tmr_expire) begin
                        retry_q <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign jam_en    = (state == ST_JAM);
    assign jam_d     = {DATA_W{jam_en}};
    assign retry_req = retry_q;
    assign late_coll = late_q;
    assign retry_lim = lim_q;

    // Jam ends only on the strobe that completes the last jam bit (R1).
    assert_jam_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(jam_en) |-> ($past(bit_stb) && $past(jam_cnt) == JAM_LAST));

    // Jam never starts while the preamble is still flagged (R2).
    assert_pre_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_en) |-> !$past(pre_act));

    // A late collision never leaves a retry pending (R5).
    assert_late_no_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        late_coll |-> (state == ST_IDLE));

    // Outcomes are exclusive and follow a strobe in the decide step (R6).
    assert_outcome_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retry_req, late_coll, retry_lim}));
    assert_decide_on_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (late_coll || retry_lim) |-> ($past(bit_stb) && $past(state) == ST_DECIDE));

    // Collision count stays below the abandon limit (R7).
    assert_attempt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        attempts < ATT_W'(MAX_ATTEMPTS));

endmodule

// File: tb/tb_hdx_coll_ctrl.sv
`timescale 1ns/1ps
module tb_hdx_coll_ctrl;
    localparam int SLOT = 16;
    localparam int JAM  = 32;
    localparam int MAXA = 16;
    localparam int CAP  = 5;
    localparam int DW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_stb = 1'b0, coll = 1'b0, pre_act = 1'b0;
    logic frm_start = 1'b0, frm_end = 1'b0;
    logic jam_en, retry_req, late_coll, retry_lim;
    logic [DW-1:0] jam_d;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hdx_coll_ctrl #(
        .SLOT_BITS(SLOT), .JAM_BITS(JAM), .MAX_ATTEMPTS(MAXA),
        .BACKOFF_CAP(CAP), .DATA_W(DW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .coll(coll),
        .pre_act(pre_act), .frm_start(frm_start), .frm_end(frm_end),
        .jam_en(jam_en), .jam_d(jam_d), .retry_req(retry_req),
        .late_coll(late_coll), .retry_lim(retry_lim)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive inputs after a falling edge, return at the next one.
    task automatic tick(input logic s, input logic c = 1'b0,
                        input logic fs = 1'b0, input logic fe = 1'b0);
        bit_stb = s; coll = c; frm_start = fs; frm_end = fe;
        @(negedge clk);
        bit_stb = 1'b0; coll = 1'b0; frm_start = 1'b0; frm_end = 1'b0;
    endtask

    function automatic int outs();
        return {28'd0, jam_en, retry_req, late_coll, retry_lim};
    endfunction

    task automatic t_reset();
        chk(outs() == 0 && jam_d == '0, "R9 outputs low in reset", outs(), 0);
    endtask

    task automatic t_idle_ignore();
        bit seen = 1'b0;
        repeat (40) begin
            tick(1'b1, 1'b1);
            if (outs() != 0) seen = 1'b1;
        end
        chk(!seen, "R10 idle collision ignored", int'(seen), 0);
    endtask

    // Frame with a collision: kind 0 retry, 1 late, 2 abandon.
    task automatic coll_frame(input int pre_hold, input int strobes, input int n,
                              input int kind, input bit coll_in_bo);
        int jam_n = 0;
        bit bad_d = 1'b0;
        int cnt = 0;
        bit jam_bo = 1'b0;
        int bits;
        pre_act = (pre_hold > 0);
        tick(1'b0, 1'b0, 1'b1);
        repeat (strobes) tick(1'b1);
        tick(1'b0, 1'b1);
        if (pre_hold > 0) begin
            bit seen = 1'b0;
            repeat (pre_hold) begin
                tick(1'b1);
                if (jam_en) seen = 1'b1;
            end
            chk(!seen && !jam_en, "R2 jam held while preamble", int'(seen), 0);
            pre_act = 1'b0;
            tick(1'b1);
        end
        chk(jam_en == 1'b1, "R1 jam begins", int'(jam_en), 1);
        while (jam_en && jam_n < 100) begin
            if (jam_d != {DW{1'b1}}) bad_d = 1'b1;
            tick(1'b1);
            jam_n++;
        end
        chk(jam_n == JAM, "R1 jam length in strobes", jam_n, JAM);
        chk(!bad_d && jam_d == '0, "R1 jam data ones then zero", int'(jam_d), 0);
        tick(1'b0);
        tick(1'b0);
        chk(!late_coll && !retry_lim && !retry_req, "R6 no outcome before strobe",
            outs(), 0);
        tick(1'b1);
        if (kind == 1) begin
            chk(late_coll && !retry_req && !retry_lim, "R5 late collision", outs(), 2);
            tick(1'b0);
            chk(!late_coll && !retry_req, "R5 one-cycle pulse, no retry", outs(), 0);
        end else if (kind == 2) begin
            chk(retry_lim && !late_coll && !retry_req, "R7 abandon at limit", outs(), 1);
            tick(1'b0);
            chk(!retry_lim && !retry_req, "R7 one-cycle pulse", outs(), 0);
        end else begin
            chk(!late_coll && !retry_lim, "R3 early collision retries", outs(), 0);
            while (!retry_req && cnt < 40000) begin
                tick(1'b1, coll_in_bo);
                cnt++;
                if (jam_en) jam_bo = 1'b1;
            end
            bits = (n < CAP) ? n : CAP;
            chk(retry_req && ((cnt - 1) % SLOT) == 0 && ((cnt - 1) / SLOT) < (1 << bits),
                "R4 backoff whole slots in range", cnt - 1, ((1 << bits) - 1) * SLOT);
            if (coll_in_bo) chk(!jam_bo, "R10 backoff collision ignored", int'(jam_bo), 0);
            tick(1'b0);
            chk(!retry_req, "R4 retry one-cycle pulse", int'(retry_req), 0);
        end
    endtask

    task automatic t_clean_frame();
        bit seen = 1'b0;
        tick(1'b0, 1'b0, 1'b1);
        repeat (20) tick(1'b1);
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        repeat (5) begin
            tick(1'b1);
            if (outs() != 0) seen = 1'b1;
        end
        chk(!seen, "R8 clean end gives no outcome", int'(seen), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_idle_ignore();
        coll_frame(0, 3, 1, 0, 1'b0);
        coll_frame(4, 0, 2, 0, 1'b0);
        coll_frame(0, SLOT - 1, 3, 0, 1'b1);
        coll_frame(0, SLOT, 0, 1, 1'b0);
        for (int i = 1; i <= 5; i++) coll_frame(0, 2, i, 0, 1'b0);
        t_clean_frame();
        for (int i = 1; i < MAXA; i++) coll_frame(0, 1, i, 0, 1'b0);
        coll_frame(0, 1, MAXA, 2, 1'b0);
        coll_frame(0, 1, 1, 0, 1'b0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule